// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Receiver with Address Filter

This block receives asynchronous serial characters from one input line, as on a shared multidrop bus such as RS-485. A frame is a low start bit, eight data bits sent least significant first, an optional ninth bit, and a high stop bit. The line is sampled sixteen times per bit. The rate is set by a divisor input that gives the number of clock cycles per sample.

When address filtering is on, the receiver discards every character whose ninth bit is 0. The host then sees only address characters. Once it finds its own address, it turns filtering off so that the data characters that follow reach it.

Received characters wait in a two-entry buffer. The character at the head of the buffer is shown on the data and status outputs. A pop pulse consumes that character. The host reads the status (ninth bit, framing error and overrun) before it pops.

Top module: `uart9_addr_rx`

## Requirements
- R1: With `rx_en` high, the idle line is 1. A frame starts with a 0 start bit, then 8 data bits, least significant first, then a 1 stop bit. One bit lasts 16 × max(`baud_div`,1) clock cycles. The byte appears on `rx_data`.
- R2: When `nine_en` is 1, a ninth bit is received between data bit 7 and the stop bit and is shown on `rx_stat[0]`. When `nine_en` is 0, `rx_stat[0]` reads 0.
- R3: When `addr_en` and `nine_en` are both 1, a character whose ninth bit is 0 is discarded and `rx_flag` does not change. A character whose ninth bit is 1 is buffered and reads `rx_stat[0]`=1.
- R4: When `addr_en` is 0, every completed character is buffered, whatever its ninth bit.
- R5: `rx_flag` is 1 exactly while the buffer holds at least one character. `rx_irq` is 1 only while both `rx_flag` and `irq_en` are 1.
- R6: When `inv_pol` is 1, the serial input is inverted before it is sampled, so the idle line is 0.
- R7: A stop bit sampled as 0 sets `rx_stat[1]` for that character only. The flag stays with the character through the buffer.
- R8: The buffer holds two characters, read in arrival order. A one-cycle `rx_pop` pulse removes the head character.
- R9: A character that completes and passes the filter while the buffer is full sets `rx_stat[2]` (overrun) and is discarded. No character is buffered while overrun is set. Overrun clears only while `rx_en` is 0.
- R10: A low pulse on the line shorter than half a bit is rejected as a false start, and no character results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input |
| rx_en | input | 1 | Receiver enable; low also clears overrun |
| nine_en | input | 1 | Ninth-bit reception |
| addr_en | input | 1 | Address filtering (needs nine_en) |
| inv_pol | input | 1 | Invert serial input |
| irq_en | input | 1 | Receive interrupt enable |
| baud_div | input | 16 | Clock cycles per oversample tick |
| rx_pop | input | 1 | Consume the head character |
| rx_data | output | 8 | Head character data |
| rx_stat | output | 3 | {overrun, framing error, ninth bit} |
| rx_flag | output | 1 | Buffer not empty |
| rx_irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `rx_pop` is pulsed only while `rx_flag` is 1. They also take for granted that the mode inputs (`nine_en`, `addr_en`, `inv_pol`, `baud_div`) change only while the line is idle between frames. The bench follows both rules: it pops only after seeing the flag set, and it changes modes only after a frame has ended and the line has been idle for at least one bit time. Frames are driven on the falling clock edge, at exactly the configured bit period.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int CNT_W      = $clog2(OVERSAMPLE);

  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
    logic       ferr;
  } rx_char_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic filter_pass(input logic addr_mode, input logic ninth);
    return !addr_mode || ninth;
  endfunction
endpackage

// File: rtl/uart9_tick_gen.sv
module uart9_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (div <= DIV_W'(1)) || (cnt_q >= div - DIV_W'(1));
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/uart9_bit_engine.sv
module uart9_bit_engine
  import uart9_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  logic     line,
  input  logic     nine,
  output logic     done,
  output rx_char_t char_out
);
  localparam logic [CNT_W-1:0] MID_A = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] MID_B = CNT_W'(OVERSAMPLE/2);
  localparam logic [CNT_W-1:0] MID_C = CNT_W'(OVERSAMPLE/2 + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVERSAMPLE - 1);

  rx_state_t        state_q;
  logic [CNT_W-1:0] scnt_q;
  logic [3:0]       bidx_q;
  logic [8:0]       shreg_q;
  logic             s_a_q, s_b_q;
  logic             done_q;
  rx_char_t         char_q;
  logic [3:0]       last_bit;
  logic             voted;

  assign last_bit = nine ? 4'd8 : 4'd7;
  assign voted    = maj3(s_a_q, s_b_q, line);
  assign done     = done_q;
  assign char_out = char_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      scnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        state_q <= S_IDLE;
        scnt_q  <= '0;
      end else if (tick) begin
        scnt_q <= scnt_q + CNT_W'(1);
        if (scnt_q == MID_A) s_a_q <= line;
        if (scnt_q == MID_B) s_b_q <= line;
        unique case (state_q)
          S_IDLE: begin
            scnt_q <= '0;
            if (!line) begin
              state_q <= S_START;
              shreg_q <= '0;
            end
          end
          S_START: begin
            if (scnt_q == MID_A && line) state_q <= S_IDLE;
            else if (scnt_q == LAST) begin
              state_q <= S_DATA;
              bidx_q  <= '0;
            end
          end
          S_DATA: begin
            if (scnt_q == MID_C) shreg_q[bidx_q] <= voted;
            if (scnt_q == LAST) begin
              if (bidx_q == last_bit) state_q <= S_STOP;
              else                    bidx_q  <= bidx_q + 4'd1;
            end
          end
          S_STOP: begin
            if (scnt_q == MID_C) begin
              done_q        <= 1'b1;
              char_q.data   <= shreg_q[7:0];
              char_q.bit9   <= nine & shreg_q[8];
              char_q.ferr   <= !voted;
              state_q       <= S_IDLE;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart9_char_fifo.sv
module uart9_char_fifo
  import uart9_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t push_char,
  input  logic     pop,
  output rx_char_t head,
  output logic     full,
  output logic     empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  rx_char_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign level   = lvl_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rptr_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mem_q[i] <= '0;
      else if (do_push && wptr_q == PTR_W'(i))  mem_q[i] <= push_char;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_next(wptr_q);
      if (do_pop)  rptr_q <= ptr_next(rptr_q);
      lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx
  import uart9_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             rx_en,
  input  logic             nine_en,
  input  logic             addr_en,
  input  logic             inv_pol,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic [2:0]       rx_stat,
  output logic             rx_flag,
  output logic             rx_irq
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [1:0]       sync_q;
  logic             line_s;
  logic             tick;
  logic             char_done;
  rx_char_t         char_new;
  rx_char_t         head;
  logic             addr_eff;
  logic             passes;
  logic             push;
  logic             full, empty;
  logic [LVL_W-1:0] level;
  logic             oerr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};
  end
  assign line_s = sync_q[1] ^ inv_pol;

  uart9_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart9_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line(line_s),
    .nine(nine_en), .done(char_done), .char_out(char_new)
  );

  assign addr_eff = addr_en & nine_en;
  assign passes   = char_done && rx_en && filter_pass(addr_eff, char_new.bit9);
  assign push     = passes && !full && !oerr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              oerr_q <= 1'b0;
    else if (!rx_en)         oerr_q <= 1'b0;
    else if (passes && full) oerr_q <= 1'b1;
  end

  uart9_char_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_char(char_new),
    .pop(rx_pop), .head(head), .full(full), .empty(empty), .level(level)
  );

  assign rx_data = head.data;
  assign rx_stat = {oerr_q, head.ferr, head.bit9};
  assign rx_flag = !empty;
  assign rx_irq  = rx_flag & irq_en;
endmodule

// File: rtl/uart9_addr_rx_chk.sv
module uart9_addr_rx_chk #(
  parameter int LVL_W = 2,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             push,
  input logic             push_bit9,
  input logic             addr_eff,
  input logic             full,
  input logic [LVL_W-1:0] level,
  input logic             oerr,
  input logic             irq,
  input logic             flag,
  input logic             irq_en,
  input logic             pop
);
  // R3
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && addr_eff) |-> push_bit9);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  // R9
  oerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oerr && en) |=> oerr);
  // R9
  oerr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !oerr);
  // R9
  oerr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oerr |-> !push);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && irq_en));
  // R5
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(pop));
endmodule

bind uart9_addr_rx uart9_addr_rx_chk #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(rx_en), .push(push), .push_bit9(char_new.bit9),
  .addr_eff(addr_eff), .full(full), .level(level), .oerr(oerr_q),
  .irq(rx_irq), .flag(rx_flag), .irq_en(irq_en), .pop(rx_pop)
);

// File: tb/uart9_addr_rx_test.sv
module uart9_addr_rx_test;
  localparam int DIV = 4;
  localparam int BIT_CLKS = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_line = 1'b1, rx_en = 1'b0, nine_en = 1'b0, addr_en = 1'b0;
  logic inv_pol = 1'b0, irq_en = 1'b0, rx_pop = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic [7:0] rx_data;
  logic [2:0] rx_stat;
  logic rx_flag, rx_irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  uart9_addr_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_en(rx_en), .nine_en(nine_en),
    .addr_en(addr_en), .inv_pol(inv_pol), .irq_en(irq_en), .baud_div(baud_div),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_stat(rx_stat), .rx_flag(rx_flag),
    .rx_irq(rx_irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_level(input logic v, input int clks);
    rx_line = v ^ inv_pol;
    idle_clks(clks);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stopv);
    drive_level(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) drive_level(d[i], BIT_CLKS);
    if (nine_en) drive_level(b9, BIT_CLKS);
    drive_level(stopv, BIT_CLKS);
    drive_level(1'b1, BIT_CLKS);
  endtask

  task automatic pop_one();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    idle_clks(1);
  endtask

  task automatic expect_head(input string req, input logic [7:0] d, input logic [2:0] st);
    check(rx_flag === 1'b1, req, rx_flag, 1);
    check(rx_data === d, req, rx_data, d);
    check(rx_stat === st, req, rx_stat, st);
  endtask

  task automatic t_reset();
    check(rx_flag === 1'b0 && rx_irq === 1'b0, "R5 reset", {rx_flag, rx_irq}, 0);
    check(rx_stat === 3'b000, "R9 reset", rx_stat, 0);
  endtask

  task automatic t_basic8();
    send(8'hA5, 1'b0, 1'b1);
    expect_head("R1", 8'hA5, 3'b000);
    pop_one();
    send(8'h3C, 1'b1, 1'b1);
    expect_head("R2 nine off", 8'h3C, 3'b000);
    pop_one();
    check(rx_flag === 1'b0, "R5 empty after pop", rx_flag, 0);
  endtask

  task automatic t_nine();
    nine_en = 1'b1;
    idle_clks(BIT_CLKS);
    send(8'h81, 1'b1, 1'b1);
    expect_head("R2", 8'h81, 3'b001);
    pop_one();
    send(8'h7E, 1'b0, 1'b1);
    expect_head("R2 ninth0", 8'h7E, 3'b000);
    pop_one();
  endtask

  task automatic t_addr();
    addr_en = 1'b1;
    idle_clks(BIT_CLKS);
    send(8'h55, 1'b0, 1'b1);
    check(rx_flag === 1'b0, "R3 data dropped", rx_flag, 0);
    send(8'h12, 1'b1, 1'b1);
    expect_head("R3 addr kept", 8'h12, 3'b001);
    pop_one();
    addr_en = 1'b0;
    idle_clks(BIT_CLKS);
    send(8'h99, 1'b0, 1'b1);
    expect_head("R4", 8'h99, 3'b000);
    pop_one();
  endtask

  task automatic t_irq();
    irq_en = 1'b0;
    send(8'h01, 1'b0, 1'b1);
    check(rx_flag === 1'b1 && rx_irq === 1'b0, "R5 irq masked", rx_irq, 0);
    irq_en = 1'b1;
    idle_clks(1);
    check(rx_irq === 1'b1, "R5 irq", rx_irq, 1);
    pop_one();
    check(rx_irq === 1'b0, "R5 irq drop", rx_irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_ferr();
    send(8'hF0, 1'b0, 1'b0);
    send(8'h0F, 1'b0, 1'b1);
    expect_head("R7 bad stop", 8'hF0, 3'b010);
    pop_one();
    expect_head("R7 next clean", 8'h0F, 3'b000);
    pop_one();
  endtask

  task automatic t_false_start();
    drive_level(1'b0, BIT_CLKS / 4);
    drive_level(1'b1, 3 * BIT_CLKS);
    check(rx_flag === 1'b0, "R10", rx_flag, 0);
  endtask

  task automatic t_overrun();
    send(8'hA1, 1'b0, 1'b1);
    send(8'hA2, 1'b0, 1'b1);
    check(rx_stat[2] === 1'b0, "R8 two fit", rx_stat[2], 0);
    send(8'hA3, 1'b0, 1'b1);
    check(rx_stat[2] === 1'b1, "R9 set", rx_stat[2], 1);
    pop_one();
    pop_one();
    check(rx_flag === 1'b0, "R9 third dropped", rx_flag, 0);
    send(8'hA4, 1'b0, 1'b1);
    check(rx_flag === 1'b0, "R9 blocked", rx_flag, 0);
    check(rx_stat[2] === 1'b1, "R9 sticky", rx_stat[2], 1);
    rx_en = 1'b0; idle_clks(2); rx_en = 1'b1; idle_clks(2);
    check(rx_stat[2] === 1'b0, "R9 cleared", rx_stat[2], 0);
    send(8'hA5, 1'b0, 1'b1);
    expect_head("R9 resumes", 8'hA5, 3'b000);
    pop_one();
  endtask

  task automatic t_order();
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    expect_head("R8 first", 8'h11, 3'b000);
    pop_one();
    expect_head("R8 second", 8'h22, 3'b000);
    pop_one();
  endtask

  task automatic t_invert();
    inv_pol = 1'b1;
    rx_line = 1'b0;
    idle_clks(2 * BIT_CLKS);
    send(8'hC3, 1'b0, 1'b1);
    expect_head("R6", 8'hC3, 3'b000);
    pop_one();
  endtask

  initial begin
    fork
      begin
        idle_clks(4);
        rst_n = 1'b1;
        idle_clks(2);
        t_reset();
        rx_en = 1'b1;
        idle_clks(BIT_CLKS);
        t_basic8();
        t_nine();
        t_addr();
        nine_en = 1'b0;
        idle_clks(BIT_CLKS);
        t_irq();
        t_ferr();
        t_false_start();
        t_order();
        t_overrun();
        t_invert();
      end
      begin
        idle_clks(150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule